// File: doc/BRIEF.md
# Speculative Load Alias Checker

This block sits beside the load and store pipes of an out-of-order core where loads may run ahead of older stores whose addresses are not yet known. Every load that executes is recorded in a small circular buffer together with its address and a program-order age tag. Loads enter in program order and leave in program order when they retire. The buffer raises a full flag so that load dispatch can stall.

When a store's address becomes known, the store presents its address and age tag on the check port. The block compares that address with every buffered load, and with a load arriving in the same cycle. A load only counts as a hit when it is younger than the store. A hit means that load read stale memory. In that case the block issues a one-cycle flush request carrying the tag of the oldest offending load. That load and everything younger must be squashed. At the same clock edge the buffer drops that load and all younger entries, so the recovery logic sees a buffer that is already trimmed.

Age is a 4-bit tag whose top bit is a wrap bit. Comparisons are made modulo 16 over a window of eight, which matches the default depth of eight entries.

Top module: `slb_alias_checker`

## Requirements
- R1: An accepted load is written at the tail of the buffer, which holds up to DEPTH (8) entries. `ld_full` is registered and is 1 exactly while DEPTH entries are held. A load presented while `ld_full` is 1 is not recorded.
- R2: A store check (`st_valid`=1) whose address equals that of at least one younger buffered load makes `flush_valid` 1 for the cycle after the check. `flush_valid` is 0 after a check with no such load.
- R3: Load tag L is younger than store tag S when (L - S) mod 16 lies in 1..7, which is the case when bit 3 of the 4-bit difference is 0 and the difference is nonzero. A load with equal or older tag never causes a flush, including across the wrap from 15 to 0.
- R4: When several younger buffered loads match, `flush_tag` is the tag of the oldest of them in buffer order.
- R5: At the edge that raises `flush_valid`, the flushed load and every younger buffered entry are removed. Older entries stay and can still match later stores.
- R6: A load presented in the same cycle as a store check is also compared. If only that load matches, it becomes the flush target. In any cycle that raises a flush, the incoming load is not recorded.
- R7: `rt_valid` removes the oldest entry. It has no effect when the buffer is empty, or when the same cycle's flush removes the oldest entry.
- R8: Synchronous active-high `rst` empties the buffer and clears `flush_valid` and `ld_full` at the next edge.
- R9: `flush_valid` is never 1 in the cycle after a cycle with `st_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Executed load to record |
| ld_addr | input | ADDR_W | Load address |
| ld_tag | input | TAG_W | Load age tag |
| ld_full | output | 1 | Buffer holds DEPTH entries; stall load dispatch |
| st_valid | input | 1 | Store address resolved; check buffer |
| st_addr | input | ADDR_W | Store address |
| st_tag | input | TAG_W | Store age tag |
| rt_valid | input | 1 | Oldest load retires |
| flush_valid | output | 1 | Memory-order violation found (registered) |
| flush_tag | output | TAG_W | Tag of oldest violating load |

## Verification
The table runs store checks against loads that share an address but are older, loads that are younger and differ in address, and several younger loads that share an address. These cases separate the age filter from the address filter, and show whether the oldest or the first-seen hit is chosen. Tags straddling the 15-to-0 wrap show whether age is decided by modular difference or by plain magnitude. After each flush, follow-up checks against addresses that the flush should have removed or kept show how much of the buffer was trimmed. A load and a store arriving together, and retires on an empty buffer, test the same-cycle rules. A directed fill to eight entries, followed by an extra load and a retire, tests the full flag and the rule that a load is dropped while the buffer is full.

// File: rtl/slb_pkg.sv
package slb_pkg;

  localparam int unsigned SLB_DEPTH  = 8;
  localparam int unsigned SLB_TAG_W  = 4;
  localparam int unsigned SLB_ADDR_W = 32;

  // a is younger than b when (a - b) mod 2^w is nonzero with its top bit clear
  function automatic logic tag_younger(input logic [15:0] a,
                                       input logic [15:0] b,
                                       input int unsigned w);
    logic [15:0] d;
    logic [15:0] mask;
    mask = (16'd1 << w) - 16'd1;
    d    = (a - b) & mask;
    return (d != 16'd0) && !d[w-1];
  endfunction

endpackage

// File: rtl/slb_entry_ram.sv
module slb_entry_ram #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [TAG_W-1:0]  wtag,
  output logic [ADDR_W-1:0] rd_addr [DEPTH],
  output logic [TAG_W-1:0]  rd_tag  [DEPTH]
);

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];

  // storage without reset; validity lives in the pointers
  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[widx] <= waddr;
      tag_mem[widx]  <= wtag;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_rd
    assign rd_addr[g] = addr_mem[g];
    assign rd_tag[g]  = tag_mem[g];
  end

endmodule

// File: rtl/slb_age_match.sv
module slb_age_match
  import slb_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [IDX_W:0]    count,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [ADDR_W-1:0] ent_addr [DEPTH],
  input  logic [TAG_W-1:0]  ent_tag  [DEPTH],
  output logic              hit_any,
  output logic [IDX_W-1:0]  hit_off,
  output logic [TAG_W-1:0]  hit_tag
);

  logic [DEPTH-1:0] hit_vec;

  // one comparator per age position, counted from the head
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [IDX_W-1:0] slot;
    logic             live;
    assign slot = head_idx + IDX_W'(i);
    assign live = (IDX_W+1)'(i) < count;
    assign hit_vec[i] = st_valid && live &&
                        (ent_addr[slot] == st_addr) &&
                        tag_younger(16'(ent_tag[slot]), 16'(st_tag), TAG_W);
  end

  // lowest position from the head is the oldest hit
  always_comb begin
    hit_any = |hit_vec;
    hit_off = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_off = IDX_W'(i);
    end
    hit_tag = ent_tag[head_idx + hit_off];
  end

  // R3: a reported hit is always younger than the checking store
  assert_hit_younger_R3: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> tag_younger(16'(hit_tag), 16'(st_tag), TAG_W));

  // R4: the chosen position lies inside the occupied region
  assert_hit_live_R4: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> ((IDX_W+1)'(hit_off) < count));

endmodule

// File: rtl/slb_ptr_ctrl.sv
module slb_ptr_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_req,
  input  logic             rt_req,
  input  logic             flush_do,
  input  logic [IDX_W-1:0] flush_off,
  output logic             ins_do,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W:0]   count,
  output logic             full_q
);

  logic [IDX_W:0] head_q, tail_q, head_n, tail_n;
  logic           rt_do;

  assign count    = tail_q - head_q;
  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];

  // an insert waits for room and is squashed by any flush this cycle (R1, R6)
  assign ins_do = ins_req && !full_q && !flush_do;
  // retire needs an entry that survives this cycle's flush (R7)
  assign rt_do  = rt_req && (count != '0) && !(flush_do && (flush_off == '0));

  always_comb begin
    head_n = head_q + (IDX_W+1)'(rt_do);
    if (flush_do) tail_n = head_q + (IDX_W+1)'(flush_off);
    else          tail_n = tail_q + (IDX_W+1)'(ins_do);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      full_q <= 1'b0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      full_q <= ((tail_n - head_n) == (IDX_W+1)'(DEPTH));
    end
  end

  // R1: occupancy never exceeds the depth
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count <= (IDX_W+1)'(DEPTH));

  // R1: a request while full never grows the buffer
  assert_full_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (full_q && ins_req) |=> (count <= $past(count)));

  // R5: a flush never leaves more entries than before
  assert_flush_trim_R5: assert property (@(posedge clk) disable iff (rst)
    flush_do |=> (count <= $past(count)));

  // R7: retire on an empty buffer with no insert leaves it empty
  assert_empty_retire_R7: assert property (@(posedge clk) disable iff (rst)
    ((count == '0) && rt_req && !ins_req) |=> (count == '0));

endmodule

// File: rtl/slb_alias_checker.sv
module slb_alias_checker
  import slb_pkg::*;
#(
  parameter int unsigned DEPTH  = SLB_DEPTH,
  parameter int unsigned ADDR_W = SLB_ADDR_W,
  parameter int unsigned TAG_W  = SLB_TAG_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [TAG_W-1:0]  ld_tag,
  output logic              ld_full,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic              rt_valid,
  output logic              flush_valid,
  output logic [TAG_W-1:0]  flush_tag
);

  logic [IDX_W-1:0]  head_idx, tail_idx, hit_off, flush_off;
  logic [IDX_W:0]    count;
  logic              ins_do, buf_hit, inc_hit, flush_do;
  logic [TAG_W-1:0]  hit_tag, flush_tag_n;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [TAG_W-1:0]  ent_tag  [DEPTH];

  slb_entry_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ram (
    .clk     (clk),
    .we      (ins_do),
    .widx    (tail_idx),
    .waddr   (ld_addr),
    .wtag    (ld_tag),
    .rd_addr (ent_addr),
    .rd_tag  (ent_tag)
  );

  slb_age_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .head_idx (head_idx),
    .count    (count),
    .st_valid (st_valid),
    .st_addr  (st_addr),
    .st_tag   (st_tag),
    .ent_addr (ent_addr),
    .ent_tag  (ent_tag),
    .hit_any  (buf_hit),
    .hit_off  (hit_off),
    .hit_tag  (hit_tag)
  );

  // the arriving load is youngest, so it only wins without a buffered hit (R6)
  assign inc_hit = st_valid && ld_valid && !ld_full && (ld_addr == st_addr) &&
                   tag_younger(16'(ld_tag), 16'(st_tag), TAG_W);
  assign flush_do    = buf_hit || inc_hit;
  assign flush_off   = buf_hit ? hit_off : count[IDX_W-1:0];
  assign flush_tag_n = buf_hit ? hit_tag : ld_tag;

  slb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .ins_req   (ld_valid),
    .rt_req    (rt_valid),
    .flush_do  (flush_do),
    .flush_off (flush_off),
    .ins_do    (ins_do),
    .head_idx  (head_idx),
    .tail_idx  (tail_idx),
    .count     (count),
    .full_q    (ld_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_valid <= 1'b0;
      flush_tag   <= '0;
    end else begin
      flush_valid <= flush_do;
      if (flush_do) flush_tag <= flush_tag_n;
    end
  end

  // R9: no flush without a store check in the previous cycle
  assert_no_spurious_flush_R9: assert property (@(posedge clk) disable iff (rst)
    !st_valid |=> !flush_valid);

  // R6: a flush cycle never records the arriving load
  assert_flush_blocks_insert_R6: assert property (@(posedge clk) disable iff (rst)
    (flush_do && ld_valid) |-> !ins_do);

  // R8: reset clears the outputs at the next edge
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!flush_valid && !ld_full));

endmodule

// File: tb/slb_alias_checker_tb.sv
module slb_alias_checker_tb;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              ld_valid, st_valid, rt_valid;
  logic [ADDR_W-1:0] ld_addr, st_addr;
  logic [TAG_W-1:0]  ld_tag, st_tag, flush_tag;
  logic              ld_full, flush_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  slb_alias_checker u_dut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag), .ld_full(ld_full),
    .st_valid(st_valid), .st_addr(st_addr), .st_tag(st_tag),
    .rt_valid(rt_valid),
    .flush_valid(flush_valid), .flush_tag(flush_tag)
  );

  typedef struct packed {
    logic       ldv; logic [7:0] lda; logic [3:0] ldt;
    logic       stv; logic [7:0] sta; logic [3:0] stt;
    logic       rtv;
    logic       fv;  logic [3:0] ft;  logic full;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b1,8'h10,4'd1,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0}, // R1 insert
    '{1'b1,8'h20,4'd2,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b1,8'h10,4'd3,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b0,8'h00,4'd0,  1'b1,8'h30,4'd0,  1'b0, 1'b0,4'd0, 1'b0}, // R2 no addr
    '{1'b0,8'h00,4'd0,  1'b1,8'h10,4'd2,  1'b0, 1'b1,4'd3, 1'b0}, // R3 older 1 skipped
    '{1'b0,8'h00,4'd0,  1'b1,8'h10,4'd0,  1'b0, 1'b1,4'd1, 1'b0}, // R5 clears 1,2
    '{1'b0,8'h00,4'd0,  1'b1,8'h20,4'd0,  1'b0, 1'b0,4'd0, 1'b0}, // R5 tag2 gone
    '{1'b1,8'h40,4'd5,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b1,8'h44,4'd6,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b1,8'h40,4'd7,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b0,8'h00,4'd0,  1'b1,8'h40,4'd4,  1'b0, 1'b1,4'd5, 1'b0}, // R4 oldest of 5,7
    '{1'b0,8'h00,4'd0,  1'b1,8'h44,4'd4,  1'b0, 1'b0,4'd0, 1'b0}, // R5 tag6 gone
    '{1'b1,8'h50,4'd14, 1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b1,8'h54,4'd15, 1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b1,8'h50,4'd0,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b1,8'h58,4'd1,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b0,8'h00,4'd0,  1'b1,8'h50,4'd15, 1'b0, 1'b1,4'd0, 1'b0}, // R3 wrap
    '{1'b0,8'h00,4'd0,  1'b0,8'h00,4'd0,  1'b1, 1'b0,4'd0, 1'b0}, // R7 retire 14
    '{1'b0,8'h00,4'd0,  1'b1,8'h50,4'd13, 1'b0, 1'b0,4'd0, 1'b0}, // R7 14 gone
    '{1'b0,8'h00,4'd0,  1'b1,8'h54,4'd13, 1'b0, 1'b1,4'd15,1'b0}, // R5 older kept
    '{1'b1,8'h60,4'd2,  1'b1,8'h60,4'd1,  1'b0, 1'b1,4'd2, 1'b0}, // R6 incoming
    '{1'b0,8'h00,4'd0,  1'b1,8'h60,4'd1,  1'b0, 1'b0,4'd0, 1'b0}, // R6 not kept
    '{1'b0,8'h00,4'd0,  1'b0,8'h00,4'd0,  1'b1, 1'b0,4'd0, 1'b0}, // R7 empty
    '{1'b1,8'h80,4'd4,  1'b0,8'h00,4'd0,  1'b0, 1'b0,4'd0, 1'b0},
    '{1'b0,8'h00,4'd0,  1'b1,8'h80,4'd3,  1'b0, 1'b1,4'd4, 1'b0}  // R7 R2
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ld_valid = 0; st_valid = 0; rt_valid = 0;
    ld_addr = '0; st_addr = '0; ld_tag = '0; st_tag = '0;
  endtask

  // one cycle: drive at falling edge, sample just after the rising edge
  task automatic step(input logic lv, input logic [31:0] la, input logic [3:0] lt,
                      input logic sv, input logic [31:0] sa, input logic [3:0] stg,
                      input logic rv);
    @(negedge clk);
    ld_valid = lv; ld_addr = la; ld_tag = lt;
    st_valid = sv; st_addr = sa; st_tag = stg; rt_valid = rv;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "full after reset", 32'(ld_full), 0);
    chk("R8", "flush after reset", 32'(flush_valid), 0);
    @(negedge clk); rst = 0;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      step(TBL[k].ldv, 32'(TBL[k].lda), TBL[k].ldt,
           TBL[k].stv, 32'(TBL[k].sta), TBL[k].stt, TBL[k].rtv);
      chk(TBL[k].stv ? "R2/R3/R4" : "R9", $sformatf("row %0d flush", k),
          32'(flush_valid), 32'(TBL[k].fv));
      if (TBL[k].fv)
        chk("R4", $sformatf("row %0d flush tag", k), 32'(flush_tag), 32'(TBL[k].ft));
      chk("R1", $sformatf("row %0d full", k), 32'(ld_full), 32'(TBL[k].full));
    end

    // R1: fill to depth with tags 8..15
    for (int i = 0; i < 8; i++) begin
      step(1, 32'h100 + 32'(i), 4'(8 + i), 0, 0, 0, 0);
      chk("R1", $sformatf("full after %0d inserts", i + 1), 32'(ld_full), (i == 7) ? 1 : 0);
    end
    // R1: load while full is dropped
    step(1, 32'h200, 4'd0, 0, 0, 0, 0);
    chk("R1", "full holds", 32'(ld_full), 1);
    step(0, 0, 0, 1, 32'h200, 4'd15, 0);
    chk("R1", "dropped load absent", 32'(flush_valid), 0);
    // R7: retire frees a slot
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R7", "full after retire", 32'(ld_full), 0);
    step(0, 0, 0, 1, 32'h107, 4'd8, 0);
    chk("R2", "youngest survivor flushed", 32'(flush_valid), 1);
    chk("R4", "flush tag 15", 32'(flush_tag), 15);

    // R8: mid-run reset empties the buffer
    step(1, 32'h300, 4'd1, 0, 0, 0, 0);
    @(negedge clk); idle(); rst = 1;
    @(posedge clk); #1;
    chk("R8", "flush in reset", 32'(flush_valid), 0);
    @(negedge clk); rst = 0;
    step(0, 0, 0, 1, 32'h300, 4'd0, 0);
    chk("R8", "buffer emptied by reset", 32'(flush_valid), 0);

    @(negedge clk); idle();
    finish_run();
  end

endmodule